// File: doc/BRIEF.md
# Multicycle Subset Processor Core

This block is a 32-bit processor core that runs a small load/store instruction set one instruction at a time. Each instruction passes through a short sequence of internal phases (fetch, decode, execute, optional memory access, optional write-back), so different instruction classes take different numbers of clock cycles. The core holds its own program counter, instruction register, a 32-entry register file, an arithmetic/logic unit and a unified word memory that stores both code and data.

Before execution, the memory is filled through a dedicated load port while reset is held. The same port reads any memory word back, so results that a program stores can be inspected. After reset is released the core starts fetching at address zero. A one-cycle retire pulse marks the last cycle of every instruction. A sticky flag reports that an undefined encoding was met.

Top module: `cpu_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the program counter reads 0, the illegal flag is 0 and the retire pulse is 0; execution begins by fetching the word at byte address 0.
- R2: Register-type instructions (opcode 0x00, shift field zero) write rd with rs op rt, where funct 0x20 is add, 0x22 sub, 0x24 and, 0x25 or, 0x27 nor and 0x26 xor. Each takes 4 cycles and advances the PC by 4. Field positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0].
- R3: Opcode 0x3C writes rt with the sign-extended immediate. Opcode 0x3D writes rt with the value of rs. Each takes 4 cycles and advances the PC by 4.
- R4: Load (opcode 0x23, 5 cycles) writes rt with the memory word at rs + sign-extended immediate. Store (opcode 0x2B, 4 cycles) writes rt to that word. The word index is byte-address bits [9:2], and a negative offset is honoured. Both advance the PC by 4.
- R5: Branch-if-equal (opcode 0x04) takes 3 cycles. When rs equals rt, the PC becomes PC+4+4*sign-extended immediate. Otherwise the PC becomes PC+4.
- R6: Jump (opcode 0x02) takes 3 cycles. It sets the PC to four zero bits, then instruction bits [25:0], then two zero bits.
- R7: Register 0 always reads as zero. Writes to it have no effect.
- R8: An undefined opcode, or a register-type word with an unknown funct or a nonzero shift field, changes no register or memory. It takes 3 cycles, advances the PC by 4 and sets the illegal flag, which stays set until reset.
- R9: Writing through the load port stores ld_wdata at word ld_addr on the clock edge. ld_rdata shows the word at ld_addr combinationally. retire_o is high for exactly the final cycle of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the core state |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 8 | Load-port word index (log2 of MEM_WORDS) |
| ld_wdata | input | 32 | Load-port write data |
| ld_rdata | output | 32 | Memory word at ld_addr |
| pc_o | output | 32 | Current program counter |
| retire_o | output | 1 | High in the last cycle of each instruction |
| illegal_o | output | 1 | Sticky undefined-instruction flag |

## Verification
A sequencer stuck in the wrong phase appears within one instruction: the gap between retire pulses departs from the 3, 4 or 5 cycles required for the opcode. A bad branch or jump target appears in the program counter in the first cycle after the retire pulse. A wrong register-file or ALU result stays hidden until a store moves it into memory, where the load port reads it back. The test program therefore stores every computed register. A missed or spurious illegal flag appears right after the offending instruction retires, and it cannot clear afterwards.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4
   } state_t;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_NOR = 3'd4,
      ALU_XOR = 3'd5
   } alu_op_t;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_MOVI  = 6'h3C;
   localparam logic [5:0] OP_MOVR  = 6'h3D;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_NOR = 6'h27;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
   import cpu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  alu_op_t          op_i,
   output logic [WIDTH-1:0] y_o
);

   always_comb begin
      unique case (op_i)
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = a_i - b_i;
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_NOR: y_o = ~(a_i | b_i);
         ALU_XOR: y_o = a_i ^ b_i;
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
   parameter int WIDTH     = 32,
   parameter int NREGS     = 32,
   parameter bit ZERO_REG0 = 1'b1,
   localparam int RAW      = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [RAW-1:0]   waddr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [RAW-1:0]   raddr_a_i,
   output logic [WIDTH-1:0] rdata_a_o,
   input  logic [RAW-1:0]   raddr_b_i,
   output logic [WIDTH-1:0] rdata_b_o
);

   logic [WIDTH-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0 && ZERO_REG0) begin : g_hard_zero
         assign regs[i] = '0;
      end else begin : g_store
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we_i && waddr_i == RAW'(i)) begin
               q <= wdata_i;
            end
         end
         assign regs[i] = q;
      end
   end

   assign rdata_a_o = regs[raddr_a_i];
   assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [AW-1:0]    raddr_a_i,
   output logic [WIDTH-1:0] rdata_a_o,
   input  logic [AW-1:0]    raddr_b_i,
   output logic [WIDTH-1:0] rdata_b_o
);

   logic [WIDTH-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         words[waddr_i] <= wdata_i;
      end
   end

   assign rdata_a_o = words[raddr_a_i];
   assign rdata_b_o = words[raddr_b_i];

endmodule

// File: rtl/cpu_core.sv
module cpu_core
   import cpu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREGS     = 32,
   parameter int MEM_WORDS = 256,
   parameter bit ZERO_REG0 = 1'b1,
   localparam int MAW      = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [MAW-1:0]    ld_addr,
   input  logic [DATA_W-1:0] ld_wdata,
   output logic [DATA_W-1:0] ld_rdata,
   output logic [DATA_W-1:0] pc_o,
   output logic              retire_o,
   output logic              illegal_o
);

   if (DATA_W != 32) begin : g_bad_width
      $error("cpu_core: DATA_W must be 32");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("cpu_core: NREGS must be 32 to match 5-bit register fields");
   end
   if ((1 << MAW) != MEM_WORDS || MAW + 2 > DATA_W) begin : g_bad_depth
      $error("cpu_core: MEM_WORDS must be a power of two within the address range");
   end

   state_t            state_q;
   logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
   logic              illegal_q;

   // instruction fields
   logic [5:0]        op, funct;
   logic [4:0]        rs, rt, rd, shamt;
   logic [DATA_W-1:0] sext;
   assign op    = ir_q[31:26];
   assign rs    = ir_q[25:21];
   assign rt    = ir_q[20:16];
   assign rd    = ir_q[15:11];
   assign shamt = ir_q[10:6];
   assign funct = ir_q[5:0];
   assign sext  = {{(DATA_W-16){ir_q[15]}}, ir_q[15:0]};

   // decode
   logic    is_r, is_lw, is_sw, is_beq, is_j, is_movi, is_movr, is_bad, fn_ok;
   alu_op_t r_op;
   always_comb begin
      fn_ok = 1'b1;
      r_op  = ALU_ADD;
      case (funct)
         FN_ADD:  r_op = ALU_ADD;
         FN_SUB:  r_op = ALU_SUB;
         FN_AND:  r_op = ALU_AND;
         FN_OR:   r_op = ALU_OR;
         FN_NOR:  r_op = ALU_NOR;
         FN_XOR:  r_op = ALU_XOR;
         default: fn_ok = 1'b0;
      endcase
      is_r    = (op == OP_RTYPE) && (shamt == 5'd0) && fn_ok;
      is_lw   = (op == OP_LOAD);
      is_sw   = (op == OP_STORE);
      is_beq  = (op == OP_BEQ);
      is_j    = (op == OP_JUMP);
      is_movi = (op == OP_MOVI);
      is_movr = (op == OP_MOVR);
      is_bad  = !(is_r | is_lw | is_sw | is_beq | is_j | is_movi | is_movr);
   end

   // register file
   logic [DATA_W-1:0] rf_a, rf_b, rf_wdata;
   logic              rf_we;
   logic [4:0]        rf_waddr;
   assign rf_we    = (state_q == ST_WB);
   assign rf_waddr = is_r ? rd : rt;
   assign rf_wdata = is_lw ? mdr_q : alu_q;

   cpu_regfile #(.WIDTH(DATA_W), .NREGS(NREGS), .ZERO_REG0(ZERO_REG0)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (rf_we),
      .waddr_i  (rf_waddr),
      .wdata_i  (rf_wdata),
      .raddr_a_i(rs),
      .rdata_a_o(rf_a),
      .raddr_b_i(rt),
      .rdata_b_o(rf_b)
   );

   // ALU operand selection
   logic [DATA_W-1:0] alu_a, alu_b, alu_y;
   alu_op_t           alu_op;
   always_comb begin
      alu_a  = a_q;
      alu_b  = b_q;
      alu_op = ALU_ADD;
      if (is_r) begin
         alu_op = r_op;
      end else if (is_movi) begin
         alu_a = '0;
         alu_b = sext;
      end else if (is_movr) begin
         alu_b = '0;
      end else if (is_lw || is_sw) begin
         alu_b = sext;
      end
   end

   cpu_alu #(.WIDTH(DATA_W)) u_alu (
      .a_i (alu_a),
      .b_i (alu_b),
      .op_i(alu_op),
      .y_o (alu_y)
   );

   // unified memory: core port shares the write side with the load port
   logic [DATA_W-1:0] mem_rdata;
   logic [MAW-1:0]    core_addr, mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic              core_we, mem_we;
   assign core_addr = (state_q == ST_FETCH) ? pc_q[MAW+1:2] : alu_q[MAW+1:2];
   assign core_we   = (state_q == ST_MEM) && is_sw;
   assign mem_we    = ld_we | core_we;
   assign mem_waddr = ld_we ? ld_addr  : core_addr;
   assign mem_wdata = ld_we ? ld_wdata : b_q;

   cpu_mem #(.WIDTH(DATA_W), .DEPTH(MEM_WORDS)) u_mem (
      .clk      (clk),
      .we_i     (mem_we),
      .waddr_i  (mem_waddr),
      .wdata_i  (mem_wdata),
      .raddr_a_i(core_addr),
      .rdata_a_o(mem_rdata),
      .raddr_b_i(ld_addr),
      .rdata_b_o(ld_rdata)
   );

   // sequencer
   logic [DATA_W-1:0] br_target, j_target;
   assign br_target = pc_q + {sext[DATA_W-3:0], 2'b00};
   assign j_target  = {4'b0000, ir_q[25:0], 2'b00};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_FETCH;
         pc_q      <= '0;
         ir_q      <= '0;
         a_q       <= '0;
         b_q       <= '0;
         alu_q     <= '0;
         mdr_q     <= '0;
         illegal_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_FETCH: begin
               ir_q    <= mem_rdata;
               pc_q    <= pc_q + DATA_W'(4);
               state_q <= ST_DECODE;
            end
            ST_DECODE: begin
               a_q     <= rf_a;
               b_q     <= rf_b;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               alu_q <= alu_y;
               if (is_beq) begin
                  if (a_q == b_q) pc_q <= br_target;
                  state_q <= ST_FETCH;
               end else if (is_j) begin
                  pc_q    <= j_target;
                  state_q <= ST_FETCH;
               end else if (is_bad) begin
                  illegal_q <= 1'b1;
                  state_q   <= ST_FETCH;
               end else if (is_lw || is_sw) begin
                  state_q <= ST_MEM;
               end else begin
                  state_q <= ST_WB;
               end
            end
            ST_MEM: begin
               mdr_q   <= mem_rdata;
               state_q <= is_lw ? ST_WB : ST_FETCH;
            end
            ST_WB: begin
               state_q <= ST_FETCH;
            end
            default: state_q <= ST_FETCH;
         endcase
      end
   end

   assign pc_o      = pc_q;
   assign illegal_o = illegal_q;
   assign retire_o  = (state_q == ST_WB)
                    | ((state_q == ST_MEM) && is_sw)
                    | ((state_q == ST_EXEC) && (is_beq || is_j || is_bad));

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
   import cpu_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] pc,
   input logic        illegal,
   input logic        retire,
   input state_t      state,
   input logic [5:0]  opcode
);

   // R1: reset holds the PC at zero and the flag clear
   a_r1_reset_pc: assert property (@(posedge clk)
      !rst_n |=> (pc == 32'd0) && !illegal);

   // R8: the illegal flag is sticky
   a_r8_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> illegal);

   // R9: after a retire pulse the next instruction is fetched
   a_r9_retire_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> (state == ST_FETCH) && !retire);

   // R2: the PC moves only at the end of fetch or execute
   a_r2_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_FETCH && state != ST_EXEC) |=> $stable(pc));

   // R5: a branch leaves execute straight for fetch
   a_r5_beq_short: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && opcode == OP_BEQ) |=> (state == ST_FETCH));

   // R4: a load passes through write-back after its memory phase
   a_r4_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MEM && opcode == OP_LOAD) |=> (state == ST_WB));

   // R6: a jump target has zero top nibble and word alignment
   a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && opcode == OP_JUMP) |=> (pc[31:28] == 4'd0) && (pc[1:0] == 2'd0));

endmodule

bind cpu_core cpu_core_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pc     (pc_o),
   .illegal(illegal_o),
   .retire (retire_o),
   .state  (state_q),
   .opcode (ir_q[31:26])
);

// File: tb/cpu_core_test.sv
module cpu_core_test;

   localparam int CLK_PERIOD = 10;
   localparam int PROG_LEN   = 35;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_wdata = '0;
   logic [31:0] ld_rdata;
   logic [31:0] pc_o;
   logic        retire_o;
   logic        illegal_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_core uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_we    (ld_we),
      .ld_addr  (ld_addr),
      .ld_wdata (ld_wdata),
      .ld_rdata (ld_rdata),
      .pc_o     (pc_o),
      .retire_o (retire_o),
      .illegal_o(illegal_o)
   );

   typedef struct packed {
      logic [31:0] pc;
      int          cyc;
      logic        ill;
      int          req;
   } exp_t;

   exp_t exp_q[$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   // driver: expected outcome of each retired instruction
   task automatic push(input logic [31:0] pc, input int cyc, input logic ill, input int req);
      exp_t e;
      e.pc = pc; e.cyc = cyc; e.ill = ill; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic ld_word(input int addr, input logic [31:0] data);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 8'(addr); ld_wdata = data;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   // monitor: compares cycle count at retire, then PC and flag one cycle later
   bit   pend = 1'b0;
   exp_t cur;
   int   cnt = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (pend) begin
            check(pc_o == cur.pc, $sformatf("R%0d next-pc", cur.req), pc_o, cur.pc);
            check(illegal_o == cur.ill, "R8 illegal flag", 32'(illegal_o), 32'(cur.ill));
            pend = 1'b0;
         end
         if (rst_n) cnt++;
         if (retire_o && exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            check(cnt == cur.cyc, $sformatf("R%0d cycle count", cur.req), 32'(cnt), 32'(cur.cyc));
            pend = 1'b1;
         end
         if (retire_o) cnt = 0;
      end
   end

   logic [31:0] prog [PROG_LEN];
   logic [31:0] memv;

   initial begin
      for (int i = 0; i < PROG_LEN; i++) prog[i] = 32'h0;
      prog[0]  = enc_i(6'h3C, 0, 1, 16'd5);          // r1 = 5
      prog[1]  = enc_i(6'h3C, 0, 2, 16'hFFFD);       // r2 = -3
      prog[2]  = enc_r(6'h20, 3, 1, 2);              // add
      prog[3]  = enc_r(6'h22, 4, 1, 2);              // sub
      prog[4]  = enc_r(6'h24, 5, 1, 2);              // and
      prog[5]  = enc_r(6'h25, 6, 1, 2);              // or
      prog[6]  = enc_r(6'h27, 7, 1, 2);              // nor
      prog[7]  = enc_r(6'h26, 8, 1, 2);              // xor
      prog[8]  = enc_i(6'h3D, 1, 9, 16'd0);          // r9 = r1
      prog[9]  = enc_i(6'h3C, 0, 0, 16'd7);          // r0 = 7 (ignored)
      for (int k = 0; k < 8; k++)                    // store r3..r9, r0
         prog[10+k] = enc_i(6'h2B, 0, (k == 7) ? 0 : 3 + k, 16'(32'h200 + 4*k));
      prog[18] = enc_i(6'h23, 0, 10, 16'h0200);      // lw r10
      prog[19] = enc_i(6'h2B, 0, 10, 16'h0220);
      prog[20] = enc_i(6'h04, 1, 9, 16'd1);          // beq taken, skip 21
      prog[21] = enc_i(6'h3C, 0, 11, 16'h0099);
      prog[22] = enc_i(6'h04, 1, 2, 16'd5);          // beq not taken
      prog[23] = {6'h3F, 26'h0000421};               // undefined
      prog[24] = {6'h02, 26'd30};                    // j word 30
      prog[30] = enc_i(6'h2B, 0, 11, 16'h0224);
      prog[31] = enc_i(6'h3C, 0, 12, 16'h0240);
      prog[32] = enc_i(6'h23, 12, 13, 16'hFFC0);     // negative offset
      prog[33] = enc_i(6'h2B, 0, 13, 16'h0228);
      prog[34] = enc_i(6'h04, 0, 0, 16'hFFFF);       // self loop

      for (int i = 0; i < PROG_LEN; i++) ld_word(i, prog[i]);
      for (int i = 128; i < 140; i++) ld_word(i, 32'hDEADBEEF);

      @(negedge clk);
      // R1: reset state
      check(pc_o == 32'd0, "R1 pc", pc_o, 32'd0);
      check(illegal_o == 1'b0, "R1 illegal", 32'(illegal_o), 32'd0);
      check(retire_o == 1'b0, "R1 retire", 32'(retire_o), 32'd0);
      // R9: load port readback
      ld_addr = 8'd2;
      #1 check(ld_rdata == prog[2], "R9 readback", ld_rdata, prog[2]);

      push(32'd4, 4, 0, 3);  push(32'd8, 4, 0, 3);
      for (int k = 0; k < 6; k++) push(32'(12 + 4*k), 4, 0, 2);
      push(32'd36, 4, 0, 3); push(32'd40, 4, 0, 7);
      for (int k = 0; k < 8; k++) push(32'(44 + 4*k), 4, 0, 4);
      push(32'd76, 5, 0, 4); push(32'd80, 4, 0, 4);
      push(32'd88, 3, 0, 5); push(32'd92, 3, 0, 5);
      push(32'd96, 3, 1, 8); push(32'd120, 3, 1, 6);
      push(32'd124, 4, 1, 4); push(32'd128, 4, 1, 3);
      push(32'd132, 5, 1, 4); push(32'd136, 4, 1, 4);
      for (int k = 0; k < 3; k++) push(32'd136, 3, 1, 5);

      @(posedge clk);
      #1 rst_n = 1'b1;

      // watchdog
      for (int w = 0; w < 2000 && (exp_q.size() > 0 || pend); w++) @(negedge clk);
      if (exp_q.size() > 0 || pend) begin
         total++; bad++;
         $display("FAIL R9 watchdog actual=%08h expected=%08h", 32'(exp_q.size()), 32'd0);
      end

      @(negedge clk);
      begin
         logic [31:0] expv [11];
         string       tags [11];
         expv = '{32'd2, 32'd8, 32'd5, 32'hFFFFFFFD, 32'd2, 32'hFFFFFFF8,
                  32'd5, 32'd0, 32'd2, 32'd0, 32'd2};
         tags = '{"R2 add", "R2 sub", "R2 and", "R2 or", "R2 nor", "R2 xor",
                  "R3 move reg", "R7 zero reg", "R4 load", "R5 skipped", "R4 neg offset"};
         for (int k = 0; k < 11; k++) begin
            ld_addr = 8'(128 + k);
            #1 memv = ld_rdata;
            check(memv == expv[k], tags[k], memv, expv[k]);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule